// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Engine

This block sits beside the access sequencer of an asynchronous DRAM controller. It owns two jobs that must never be skipped. The first is the power-up ritual: a long idle pause after reset, followed by a burst of dummy row-strobe cycles. The second is the steady refresh that keeps stored charge alive. Every refresh is a CAS-before-RAS cycle. The column strobe falls first, the device supplies the row from its own counter, and the address, data, output-enable and write-enable lines play no part. The engine never touches them.

The engine shares the strobes with the access sequencer through a request/grant handshake. It raises `ref_req`, waits until `ref_grant` is sampled high, drives `ras_n` and `cas_n` while `bus_own` is high, and drops the request once it has no more work. `ready` stays low until initialisation is complete, so normal traffic is gated until then. A free-running interval timer produces one refresh token every `RETENTION_CYCLES / ROWS` clocks, which covers every row within the retention window. Tokens that arrive while the grant is held back pile up in a saturating debt counter. When the grant comes, they are paid back-to-back. A wrapping counter reports the refreshes completed after initialisation.

The sequencer is a single state machine with the states PAUSE, IDLE, REQ, CAS, RAS and PRE. Its transitions are:
- PAUSE→REQ when the power-up pause expires.
- IDLE→REQ when refresh work is owed.
- REQ→CAS when the grant is seen.
- CAS→RAS after the column-lead time.
- RAS→PRE after the row-low time.
- PRE→CAS (grant still held) or PRE→REQ (grant dropped) when more work remains.
- PRE→IDLE when no work remains.

Top module: `dram_refresh_engine`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is reasserted, `ref_req`, `bus_own` and `ready` are 0, `ras_n` and `cas_n` are 1, and `refresh_count` is 0.
- R2: `ref_req` first reads 1 exactly `PAUSE_CYCLES` clock cycles after reset is released, and neither strobe goes low before that.
- R3: Exactly `INIT_CYCLES` strobe cycles complete before `ready` rises. `refresh_count` is still 0 when `ready` rises, and `ready` then stays 1 until the next reset.
- R4: A strobe cycle starts only on the cycle after `ref_grant` is seen high. While the grant is withheld, `ref_req` stays 1 and both strobes stay high (1).
- R5: In each cycle, `cas_n` goes low (0) exactly `CAS_LEAD` clocks before `ras_n` goes low. `ras_n` is never low while `cas_n` is high, and both strobes return high on the same clock.
- R6: `ras_n` stays low for exactly `RAS_LOW` clocks. Both strobes then stay high for at least `PRECHARGE` clocks before `cas_n` falls again, including inside a back-to-back burst.
- R7: Once `ready` is 1, refresh tokens arrive every `RETENTION_CYCLES / ROWS` clocks (integer division). With a prompt grant, successive `ref_req` rises are exactly that far apart, and the refresh count keeps pace with the tokens.
- R8: Up to `MAX_OWED` tokens are held while the grant is withheld and are paid back-to-back once it arrives. Tokens beyond `MAX_OWED` are dropped.
- R9: A token that arrives in the same clock as a refresh launch is kept, so no refresh is lost to the collision.
- R10: `refresh_count` rises by exactly one per completed post-initialisation refresh and wraps from all-ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_grant | input | 1 | Strobe ownership granted by the access sequencer |
| ref_req | output | 1 | Engine asks for, or holds, the strobes |
| bus_own | output | 1 | Engine is driving the strobes this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ready | output | 1 | Initialisation complete; normal traffic allowed |
| refresh_count | output | COUNT_W | Wrapping count of completed refreshes |

## Verification
A new refresh token from the interval timer can land in the same clock in which a pending refresh is launched. When that happens, the debt counter sees an increment and a decrement together. The bench provokes this by withholding the grant and releasing it at a sweep of offsets just before and after the next token, so that one offset makes the launch fall exactly on the token edge. It judges the outcome by conservation rather than by the burst size: at a mid-interval sample the completed-refresh count must equal the number of tokens elapsed since a reference request, so a token swallowed by the collision shows up as a short count.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_REQ,
        ST_CAS,
        ST_RAS,
        ST_PRE
    } seq_state_t;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int PERIOD = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic launch,
    output logic pending
);
    localparam int W = $clog2(MAX_OWED + 1);
    localparam logic [W-1:0] CAP = W'(MAX_OWED);

    logic [W-1:0] owed;
    logic         inc;

    // a token is kept when there is room, or when a launch frees a slot in the same clock
    assign inc = tick && ((owed != CAP) || launch);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            unique case ({inc, launch})
                2'b10:   owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign pending = (owed != '0);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= CAP);

    // R8
    launch_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (owed != '0));

    // R9
    collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && launch) |=> (owed == $past(owed)));

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
    import dram_refresh_pkg::*;
#(
    parameter int PAUSE_CYCLES = 10000,
    parameter int INIT_CYCLES  = 8,
    parameter int CAS_LEAD     = 1,
    parameter int RAS_LOW      = 3,
    parameter int PRECHARGE    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic pending,
    output logic req,
    output logic own,
    output logic ras_n,
    output logic cas_n,
    output logic ready,
    output logic launch,
    output logic done
);
    localparam int TMAX_A = (PAUSE_CYCLES > CAS_LEAD) ? PAUSE_CYCLES : CAS_LEAD;
    localparam int TMAX_B = (RAS_LOW > PRECHARGE) ? RAS_LOW : PRECHARGE;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int IW     = $clog2(INIT_CYCLES + 1);

    localparam logic [TW-1:0] PAUSE_LAST = TW'(PAUSE_CYCLES - 1);
    localparam logic [TW-1:0] LEAD_LAST  = TW'(CAS_LEAD - 1);
    localparam logic [TW-1:0] LOW_LAST   = TW'(RAS_LOW - 1);
    localparam logic [TW-1:0] PRE_LAST   = TW'(PRECHARGE - 1);
    localparam logic [IW-1:0] INIT_LOAD  = IW'(INIT_CYCLES);
    localparam logic [IW-1:0] INIT_ONE   = IW'(1);

    seq_state_t     state, nxt;
    logic [TW-1:0]  tcnt;
    logic [IW-1:0]  init_left;
    logic           phase_end;
    logic           more_work;
    logic           timed;

    always_comb begin
        phase_end = 1'b0;
        timed     = 1'b1;
        unique case (state)
            ST_PAUSE: phase_end = (tcnt == PAUSE_LAST);
            ST_CAS:   phase_end = (tcnt == LEAD_LAST);
            ST_RAS:   phase_end = (tcnt == LOW_LAST);
            ST_PRE:   phase_end = (tcnt == PRE_LAST);
            default:  timed     = 1'b0;
        endcase
    end

    assign more_work = ready ? pending : (init_left != INIT_ONE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_PAUSE: if (phase_end) nxt = ST_REQ;
            ST_IDLE:  if (pending)   nxt = ST_REQ;
            ST_REQ:   if (grant)     nxt = ST_CAS;
            ST_CAS:   if (phase_end) nxt = ST_RAS;
            ST_RAS:   if (phase_end) nxt = ST_PRE;
            ST_PRE: begin
                if (phase_end) begin
                    if (!more_work)  nxt = ST_IDLE;
                    else if (grant)  nxt = ST_CAS;
                    else             nxt = ST_REQ;
                end
            end
            default: nxt = ST_PAUSE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PAUSE;
        end else begin
            state <= nxt;
        end
    end

    // phase timer, initialisation budget and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt      <= '0;
            init_left <= INIT_LOAD;
            ready     <= 1'b0;
        end else begin
            if (nxt != state)  tcnt <= '0;
            else if (timed)    tcnt <= tcnt + 1'b1;

            if (!ready && state == ST_PRE && phase_end) begin
                init_left <= init_left - 1'b1;
                if (init_left == INIT_ONE) ready <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        req   = 1'b0;
        own   = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        unique case (state)
            ST_REQ: req = 1'b1;
            ST_CAS: begin req = 1'b1; own = 1'b1; cas_n = 1'b0; end
            ST_RAS: begin req = 1'b1; own = 1'b1; cas_n = 1'b0; ras_n = 1'b0; end
            ST_PRE: begin req = 1'b1; own = 1'b1; end
            default: ;
        endcase
    end

    assign launch = ready && (nxt == ST_CAS) && (state != ST_CAS);
    assign done   = ready && (state == ST_PRE) && phase_end;

    // R5
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R5
    cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    // R5
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> $rose(cas_n));

    // R4
    grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own) |-> $past(grant));

    // R3
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R3
    init_uncounted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !done);

endmodule

// File: rtl/dram_refresh_engine.sv
module dram_refresh_engine #(
    parameter int PAUSE_CYCLES     = 10000,
    parameter int INIT_CYCLES      = 8,
    parameter int RETENTION_CYCLES = 3200000,
    parameter int ROWS             = 4096,
    parameter int CAS_LEAD         = 1,
    parameter int RAS_LOW          = 3,
    parameter int PRECHARGE        = 2,
    parameter int MAX_OWED         = 8,
    parameter int COUNT_W          = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_grant,
    output logic               ref_req,
    output logic               bus_own,
    output logic               ras_n,
    output logic               cas_n,
    output logic               ready,
    output logic [COUNT_W-1:0] refresh_count
);
    localparam int INTERVAL = RETENTION_CYCLES / ROWS;

    logic tick;
    logic launch;
    logic pending;
    logic done;

    refresh_interval_timer #(
        .PERIOD (INTERVAL)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ready),
        .tick  (tick)
    );

    refresh_debt_counter #(
        .MAX_OWED (MAX_OWED)
    ) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .launch  (launch),
        .pending (pending)
    );

    refresh_sequencer #(
        .PAUSE_CYCLES (PAUSE_CYCLES),
        .INIT_CYCLES  (INIT_CYCLES),
        .CAS_LEAD     (CAS_LEAD),
        .RAS_LOW      (RAS_LOW),
        .PRECHARGE    (PRECHARGE)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant   (ref_grant),
        .pending (pending),
        .req     (ref_req),
        .own     (bus_own),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .ready   (ready),
        .launch  (launch),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh_count <= '0;
        end else if (done) begin
            refresh_count <= refresh_count + 1'b1;
        end
    end

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_count != $past(refresh_count)) |->
            (refresh_count == COUNT_W'($past(refresh_count) + 1'b1)));

    // R4
    own_under_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> ref_req);

endmodule

// File: tb/dram_refresh_engine_tb.sv
`timescale 1ns/1ps
module dram_refresh_engine_tb;

    localparam int PAUSE  = 25;
    localparam int INIT   = 8;
    localparam int RET    = 1024;
    localparam int ROWS   = 16;
    localparam int LEAD   = 1;
    localparam int LOWW   = 3;
    localparam int PREW   = 2;
    localparam int MAXO   = 3;
    localparam int CW     = 4;
    localparam int IV     = RET / ROWS;

    typedef struct packed {
        int hold;
        int burst;
        bit chk;
        bit cons;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{10,         1,    1'b1, 1'b0},
        '{IV + 10,    2,    1'b1, 1'b0},
        '{2*IV + 10,  3,    1'b1, 1'b0},
        '{IV - 4,     0,    1'b0, 1'b0},
        '{IV - 3,     0,    1'b0, 1'b0},
        '{IV - 2,     0,    1'b0, 1'b0},
        '{IV - 1,     0,    1'b0, 1'b0},
        '{IV,         0,    1'b0, 1'b0},
        '{IV + 1,     0,    1'b0, 1'b0},
        '{IV + 2,     0,    1'b0, 1'b1},
        '{4*IV + 10,  MAXO, 1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_grant = 1'b0;
    logic          ref_req;
    logic          bus_own;
    logic          ras_n;
    logic          cas_n;
    logic          ready;
    logic [CW-1:0] refresh_count;

    int  total = 0;
    int  fails = 0;
    int  cyc = 0;
    int  falls = 0;
    bit  allow = 1'b1;
    bit  saw_wrap = 1'b0;
    bit  finished = 1'b0;

    dram_refresh_engine #(
        .PAUSE_CYCLES     (PAUSE),
        .INIT_CYCLES      (INIT),
        .RETENTION_CYCLES (RET),
        .ROWS             (ROWS),
        .CAS_LEAD         (LEAD),
        .RAS_LOW          (LOWW),
        .PRECHARGE        (PREW),
        .MAX_OWED         (MAXO),
        .COUNT_W          (CW)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_grant     (ref_grant),
        .ref_req       (ref_req),
        .bus_own       (bus_own),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .ready         (ready),
        .refresh_count (refresh_count)
    );

    initial forever #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // grant driver: one cycle after the request is seen, when the test allows it
    initial forever begin
        @(negedge clk);
        #1;
        ref_grant = ref_req && allow;
    end

    // cycle counter and strobe monitor
    initial begin : monitor
        bit p_ras, p_cas, seen;
        int lead_run, low_run, gap_run;
        logic [CW-1:0] p_cnt;
        p_ras = 1'b1; p_cas = 1'b1; seen = 1'b0;
        lead_run = 0; low_run = 0; gap_run = 0; p_cnt = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                p_ras = 1'b1; p_cas = 1'b1; seen = 1'b0;
                p_cnt = '0;
            end else begin
                if (!cas_n && p_cas) begin
                    // R6 precharge before a new column fall
                    if (seen) check(gap_run >= PREW, "R6 precharge gap", gap_run, PREW);
                    lead_run = 0;
                end
                if (!ras_n && p_ras) begin
                    falls++;
                    // R5 column lead before row fall
                    check(lead_run == LEAD, "R5 cas lead", lead_run, LEAD);
                    low_run = 0;
                end
                if (ras_n && !p_ras) begin
                    // R6 row low width, R5 joint release
                    check(low_run == LOWW, "R6 ras low width", low_run, LOWW);
                    check(cas_n == 1'b1, "R5 joint release", int'(cas_n), 1);
                    gap_run = 0;
                    seen = 1'b1;
                end
                if (!ras_n && cas_n) check(1'b0, "R5 ras low with cas high", 1, 0);
                if (!cas_n && ras_n) lead_run++;
                if (!ras_n) low_run++;
                if (ras_n && cas_n) gap_run++;
                if (refresh_count != p_cnt) begin
                    // R10 single step
                    check(refresh_count == p_cnt + 1'b1, "R10 count step",
                          int'(refresh_count), int'(p_cnt + 1'b1));
                    if (p_cnt == '1) saw_wrap = 1'b1;
                end
                p_ras = ras_n; p_cas = cas_n; p_cnt = refresh_count;
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin : stim
        int n, t0, c0, tprev, f0, f1, burst, m;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!ref_req && !bus_own && !ready, "R1 reset controls", int'({ref_req, bus_own, ready}), 0);
        check(ras_n && cas_n, "R1 reset strobes", int'({ras_n, cas_n}), 3);
        check(refresh_count == '0, "R1 reset count", int'(refresh_count), 0);

        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!ref_req);
        check(n == PAUSE, "R2 pause length", n, PAUSE);
        check(falls == 0, "R2 quiet during pause", falls, 0);

        while (!ready) @(negedge clk);
        check(falls == INIT, "R3 init cycles", falls, INIT);
        check(refresh_count == '0, "R3 init not counted", int'(refresh_count), 0);

        // R7 interval with prompt grant
        while (ref_req) @(negedge clk);
        while (!ref_req) @(negedge clk);
        t0 = cyc; c0 = int'(refresh_count); tprev = t0;
        for (int k = 0; k < 2; k++) begin
            while (ref_req) @(negedge clk);
            while (!ref_req) @(negedge clk);
            check(cyc - tprev == IV, "R7 request spacing", cyc - tprev, IV);
            tprev = cyc;
        end
        while (((cyc - t0) % IV) != IV / 2) @(negedge clk);
        m = (cyc - t0) / IV;
        check(int'(refresh_count) == (c0 + m + 1) % (1 << CW), "R7 count keeps pace",
              int'(refresh_count), (c0 + m + 1) % (1 << CW));

        // withheld-grant vectors
        for (int v = 0; v < NV; v++) begin
            while (ref_req) @(negedge clk);
            allow = 1'b0;
            while (!ref_req) @(negedge clk);
            f0 = falls;
            repeat (VECS[v].hold) @(negedge clk);
            // R4 nothing moves without a grant
            check(falls == f0 && ref_req && ras_n && cas_n, "R4 held off without grant",
                  falls - f0, 0);
            allow = 1'b1;
            f1 = falls;
            while (ref_req) @(negedge clk);
            burst = falls - f1;
            // R8 owed refreshes paid back-to-back, capped
            if (VECS[v].chk) check(burst == VECS[v].burst, "R8 burst size", burst, VECS[v].burst);
            if (VECS[v].cons) begin
                while (((cyc - t0) % IV) != IV / 2) @(negedge clk);
                m = (cyc - t0) / IV;
                // R9 collision sweep loses no token
                check(int'(refresh_count) == (c0 + m + 1) % (1 << CW), "R9 token conservation",
                      int'(refresh_count), (c0 + m + 1) % (1 << CW));
            end
        end

        check(saw_wrap, "R10 count wrapped", int'(saw_wrap), 1);
        check(ready, "R3 ready held", int'(ready), 1);

        // R1 reset during operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!ready && !ref_req && refresh_count == '0, "R1 reset mid-run",
              int'({ready, ref_req}), 0);
        finish_run();
    end

endmodule